// File: doc/BRIEF.md
# Banked Dual-Port Word Memory with Registered Read Tree

This block is a large word memory assembled from many small, independent banks. Each bank stands for one on-chip block RAM. A shared clock drives two ports. Port A only reads and is intended for instruction fetch. Port B reads and writes, and its write enable has one bit for each half of the word.

Every access is decoded to a single bank. The bank outputs are then gathered by a separate tree of 4:1 multiplexers for each port. A 2:1 level closes the tree when the bank count is an odd power of two. A parameter mask can place a register after any level of the tree. The bank-select bits and a valid flag move through those registers together with the data, so each level uses the select of the request it is carrying. The total latency can therefore be set against the clock rate.

An optional wide mode reads four neighbouring banks as one quadruple-width word. That wide word is registered, and a final 4:1 stage then chooses the lane using the two lowest address bits. With no stage registers and wide mode off, the block behaves as a plain RAM with one cycle of read latency.

Defaults are kept small: 16 banks of 8 words of 18 bits. A build for full size would use 128 banks of 2048 words, which gives 256K words.

Top module: `banked_dpram`

## Requirements
- R1: While reset (rstN low) is asserted, aRdValid and bRdValid are low.
- R2: A write on port B updates bits DATA_W-1 down to DATA_W/2 when bWrEn[1] is set, and bits DATA_W/2-1 down to 0 when bWrEn[0] is set. A half whose enable bit is clear keeps its previous contents.
- R3: Read latency is 1 cycle, plus one cycle for each set bit of PIPE_MASK. Bit l of PIPE_MASK places a register after tree level l, where level 0 is nearest the banks. Wide mode adds one more cycle. With PIPE_MASK zero and wide mode off, the latency is 1.
- R4: A read valid output is high in exactly the cycles that lie one read latency after a read request on that port. It stays low after write-only cycles and after idle cycles.
- R5: If port B reads and writes the same address in the same cycle, the read returns the data held before the write.
- R6: If port A reads an address in the same cycle that port B writes it, port A gets the old data. A later read on port A gets the new data.
- R7: The two ports read different addresses in the same cycle without interfering, and each returns its own word.
- R8: Each port accepts one read per cycle, with no gaps, and returns correct data when consecutive reads hit different banks.
- R9: In normal mode the upper address bits choose the bank and the lower bits choose the word within it. Every address across the full capacity holds an independent word.
- R10: In wide mode, address bits [1:0] choose the bank inside a group of four. The remaining low bits choose the word, and the top bits choose the group. Reads return the word for the addressed lane.
- R11: In any cycle where a port's valid output is low, that port's read data keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rstN | input | 1 | Asynchronous active-low reset of the read pipeline |
| aRdEn | input | 1 | Port A read request |
| aAddr | input | ADDR_W | Port A word address |
| aRdData | output | DATA_W | Port A read data |
| aRdValid | output | 1 | Port A read data valid |
| bRdEn | input | 1 | Port B read request |
| bWrEn | input | 2 | Port B write enable, one bit per half word |
| bAddr | input | ADDR_W | Port B word address |
| bWrData | input | DATA_W | Port B write data |
| bRdData | output | DATA_W | Port B read data |
| bRdValid | output | 1 | Port B read data valid |

## Verification
The bench drives three builds at once: the plain baseline, a deeper tree with a final 2:1 level and every level registered, and a wide-mode build. It goes after the cases where a delayed select gets out of step with its data. Back-to-back reads that change bank on every cycle would then return a neighbour bank's word, and a valid flag that is one cycle early or late would show up against the latency model. It also covers same-cycle write/read collisions on both ports, where a write-first bank would return the new word. Half-word writes are checked, where a swapped or ignored enable bit would damage the other half. Finally, the outputs are watched during idle cycles after a read, where data that moves without a valid flag would be caught.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

  // Strobes handed from the control slice to the datapath.
  typedef struct packed {
    logic       aRead;
    logic       bRead;
    logic [1:0] bWrite;
  } memStrobe_t;

  // Number of registered tree levels selected by a stage mask.
  function automatic int stageCount(input logic [7:0] mask, input int levels);
    int n;
    n = 0;
    for (int l = 0; l < levels; l++) begin
      if (mask[l]) n++;
    end
    return n;
  endfunction

endpackage

// File: rtl/dpram_ctrl.sv
module dpram_ctrl
  import dpram_pkg::*;
(
  input  logic       aRdEn,
  input  logic       bRdEn,
  input  logic [1:0] bWrEn,
  output memStrobe_t strobe
);

  always_comb begin
    strobe.aRead  = aRdEn;
    strobe.bRead  = bRdEn;
    strobe.bWrite = bWrEn;
  end

endmodule

// File: rtl/ram_bank.sv
module ram_bank #(
  parameter int DATA_W = 18,
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int LO_W  = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aEn,
  input  logic [AW-1:0]     aAddr,
  output logic [DATA_W-1:0] aDout,
  input  logic              bEn,
  input  logic [1:0]        bWe,
  input  logic [AW-1:0]     bAddr,
  input  logic [DATA_W-1:0] bDin,
  output logic [DATA_W-1:0] bDout
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Half-word writes; the read registers below sample the pre-write contents.
  always_ff @(posedge clk) begin
    if (bWe[0]) mem[bAddr][LO_W-1:0]      <= bDin[LO_W-1:0];
    if (bWe[1]) mem[bAddr][DATA_W-1:LO_W] <= bDin[DATA_W-1:LO_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aDout <= '0;
      bDout <= '0;
    end else begin
      if (aEn) aDout <= mem[aAddr];
      if (bEn) bDout <= mem[bAddr];
    end
  end

endmodule

// File: rtl/mux_tree.sv
module mux_tree #(
  parameter int          LEAVES    = 16,
  parameter int          W         = 18,
  parameter int          TAG_W     = 1,
  parameter logic [7:0]  PIPE_MASK = 8'h00,
  localparam int SEL_BITS = $clog2(LEAVES),
  localparam int LVL4     = SEL_BITS / 2,
  localparam int NLVL     = LVL4 + (SEL_BITS % 2)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [LEAVES*W-1:0]       leavesIn,
  input  logic [TAG_W+SEL_BITS-1:0] selIn,
  output logic [W-1:0]              dataOut,
  output logic [TAG_W-1:0]          tagOut
);

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    localparam int BITS   = (l < LVL4) ? 2 : 1;
    localparam int IN_SW  = TAG_W + SEL_BITS - 2 * l;
    localparam int OUT_SW = IN_SW - BITS;
    localparam int CNT    = LEAVES >> (2 * l + BITS);

    logic [(CNT<<BITS)*W-1:0] dIn;
    logic [IN_SW-1:0]         sIn;
    logic [CNT*W-1:0]         dNext;
    logic [CNT*W-1:0]         levelData;
    logic [OUT_SW-1:0]        levelSel;

    if (l == 0) begin : g_src
      assign dIn = leavesIn;
      assign sIn = selIn;
    end else begin : g_src
      assign dIn = g_lvl[l-1].levelData;
      assign sIn = g_lvl[l-1].levelSel;
    end

    always_comb begin
      dNext = '0;
      for (int i = 0; i < CNT; i++) begin
        dNext[i*W +: W] = dIn[((i << BITS) + int'(sIn[BITS-1:0])) * W +: W];
      end
    end

    if (PIPE_MASK[l]) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          levelData <= '0;
          levelSel  <= '0;
        end else begin
          levelData <= dNext;
          levelSel  <= sIn[IN_SW-1:BITS];
        end
      end
    end else begin : g_wire
      assign levelData = dNext;
      assign levelSel  = sIn[IN_SW-1:BITS];
    end
  end

  assign dataOut = g_lvl[NLVL-1].levelData;
  assign tagOut  = g_lvl[NLVL-1].levelSel;

endmodule

// File: rtl/dpram_datapath.sv
module dpram_datapath
  import dpram_pkg::*;
#(
  parameter int         DATA_W     = 18,
  parameter int         BANK_DEPTH = 8,
  parameter int         NUM_BANKS  = 16,
  parameter logic [7:0] PIPE_MASK  = 8'h00,
  parameter bit         WIDE       = 1'b0,
  localparam int WORD_W = $clog2(BANK_DEPTH),
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int ADDR_W = WORD_W + BANK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrobe_t        strobe,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [DATA_W-1:0] bWrData,
  output logic [DATA_W-1:0] aRdData,
  output logic              aRdValid,
  output logic [DATA_W-1:0] bRdData,
  output logic              bRdValid
);

  localparam int GROUPS = NUM_BANKS / 4;

  logic [ADDR_W-1:0]           portAddr [2];
  logic                        portEn   [2];
  logic [BANK_W-1:0]           bankIdx  [2];
  logic [WORD_W-1:0]           wordIdx  [2];
  logic [NUM_BANKS*DATA_W-1:0] leafA, leafB;
  logic [DATA_W-1:0]           rdData   [2];
  logic                        rdValid  [2];

  assign portAddr[0] = aAddr;
  assign portAddr[1] = bAddr;
  assign portEn[0]   = strobe.aRead;
  assign portEn[1]   = strobe.bRead;

  // Address decode: bank and word index per port.
  for (genvar p = 0; p < 2; p++) begin : g_dec
    if (WIDE) begin : g_wide
      assign bankIdx[p] = {portAddr[p][ADDR_W-1:WORD_W+2], portAddr[p][1:0]};
      assign wordIdx[p] = portAddr[p][WORD_W+1:2];
    end else begin : g_flat
      assign bankIdx[p] = portAddr[p][ADDR_W-1:WORD_W];
      assign wordIdx[p] = portAddr[p][WORD_W-1:0];
    end
  end

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    ram_bank #(.DATA_W(DATA_W), .DEPTH(BANK_DEPTH)) u_bank (
      .clk   (clk),
      .rstN  (rstN),
      .aEn   (strobe.aRead),
      .aAddr (wordIdx[0]),
      .aDout (leafA[k*DATA_W +: DATA_W]),
      .bEn   (strobe.bRead),
      .bWe   (strobe.bWrite & {2{bankIdx[1] == BANK_W'(k)}}),
      .bAddr (wordIdx[1]),
      .bDin  (bWrData),
      .bDout (leafB[k*DATA_W +: DATA_W])
    );
  end

  // Per-port read path: its own select/valid register and its own tree.
  for (genvar p = 0; p < 2; p++) begin : g_port
    logic [NUM_BANKS*DATA_W-1:0] leaves;
    logic [BANK_W-1:0]           selReg;
    logic                        valReg;

    assign leaves = (p == 0) ? leafA : leafB;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        selReg <= '0;
        valReg <= 1'b0;
      end else begin
        valReg <= portEn[p];
        if (portEn[p]) selReg <= bankIdx[p];
      end
    end

    if (WIDE) begin : g_wide
      logic [4*DATA_W-1:0] treeWord, wideWord;
      logic [2:0]          treeTag;
      logic [1:0]          wideLane;
      logic                wideValid;

      mux_tree #(.LEAVES(GROUPS), .W(4*DATA_W), .TAG_W(3), .PIPE_MASK(PIPE_MASK)) u_tree (
        .clk      (clk),
        .rstN     (rstN),
        .leavesIn (leaves),
        .selIn    ({valReg, selReg[1:0], selReg[BANK_W-1:2]}),
        .dataOut  (treeWord),
        .tagOut   (treeTag)
      );

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          wideWord  <= '0;
          wideLane  <= '0;
          wideValid <= 1'b0;
        end else begin
          wideWord  <= treeWord;
          wideLane  <= treeTag[1:0];
          wideValid <= treeTag[2];
        end
      end

      assign rdData[p]  = wideWord[int'(wideLane)*DATA_W +: DATA_W];
      assign rdValid[p] = wideValid;
    end else begin : g_flat
      logic [0:0] treeTag;

      mux_tree #(.LEAVES(NUM_BANKS), .W(DATA_W), .TAG_W(1), .PIPE_MASK(PIPE_MASK)) u_tree (
        .clk      (clk),
        .rstN     (rstN),
        .leavesIn (leaves),
        .selIn    ({valReg, selReg}),
        .dataOut  (rdData[p]),
        .tagOut   (treeTag)
      );

      assign rdValid[p] = treeTag[0];
    end
  end

  assign aRdData  = rdData[0];
  assign aRdValid = rdValid[0];
  assign bRdData  = rdData[1];
  assign bRdValid = rdValid[1];

endmodule

// File: rtl/banked_dpram.sv
module banked_dpram
  import dpram_pkg::*;
#(
  parameter int         DATA_W     = 18,
  parameter int         BANK_DEPTH = 8,
  parameter int         NUM_BANKS  = 16,
  parameter logic [7:0] PIPE_MASK  = 8'h00,
  parameter bit         WIDE       = 1'b0,
  localparam int ADDR_W = $clog2(BANK_DEPTH) + $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aRdEn,
  input  logic [ADDR_W-1:0] aAddr,
  output logic [DATA_W-1:0] aRdData,
  output logic              aRdValid,
  input  logic              bRdEn,
  input  logic [1:0]        bWrEn,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [DATA_W-1:0] bWrData,
  output logic [DATA_W-1:0] bRdData,
  output logic              bRdValid
);

  memStrobe_t strobe;

  dpram_ctrl u_ctrl (
    .aRdEn  (aRdEn),
    .bRdEn  (bRdEn),
    .bWrEn  (bWrEn),
    .strobe (strobe)
  );

  dpram_datapath #(
    .DATA_W     (DATA_W),
    .BANK_DEPTH (BANK_DEPTH),
    .NUM_BANKS  (NUM_BANKS),
    .PIPE_MASK  (PIPE_MASK),
    .WIDE       (WIDE)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .aAddr    (aAddr),
    .bAddr    (bAddr),
    .bWrData  (bWrData),
    .aRdData  (aRdData),
    .aRdValid (aRdValid),
    .bRdData  (bRdData),
    .bRdValid (bRdValid)
  );

endmodule

// File: rtl/banked_dpram_checks.sv
module banked_dpram_checks
  import dpram_pkg::*;
#(
  parameter int         DATA_W    = 18,
  parameter int         NUM_BANKS = 16,
  parameter logic [7:0] PIPE_MASK = 8'h00,
  parameter bit         WIDE      = 1'b0
) (
  input logic              clk,
  input logic              rstN,
  input logic              aRdEn,
  input logic              bRdEn,
  input logic              aRdValid,
  input logic              bRdValid,
  input logic [DATA_W-1:0] aRdData,
  input logic [DATA_W-1:0] bRdData
);

  localparam int LEAF_N = WIDE ? NUM_BANKS / 4 : NUM_BANKS;
  localparam int LVLS   = ($clog2(LEAF_N) + 1) / 2;
  localparam int LAT    = 1 + stageCount(PIPE_MASK, LVLS) + (WIDE ? 1 : 0);

  logic [LAT-1:0] aHist, bHist;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aHist <= '0;
      bHist <= '0;
    end else begin
      aHist <= LAT'({aHist, aRdEn});
      bHist <= LAT'({bHist, bRdEn});
    end
  end

  // R4: valid appears exactly one latency after each request
  a_r4_a_valid: assert property (@(posedge clk) disable iff (!rstN)
    aRdValid == aHist[LAT-1]);
  a_r4_b_valid: assert property (@(posedge clk) disable iff (!rstN)
    bRdValid == bHist[LAT-1]);

  // R11: data does not move while valid is low
  a_r11_a_hold: assert property (@(posedge clk) disable iff (!rstN)
    !aRdValid |-> $stable(aRdData));
  a_r11_b_hold: assert property (@(posedge clk) disable iff (!rstN)
    !bRdValid |-> $stable(bRdData));

endmodule

bind banked_dpram banked_dpram_checks #(
  .DATA_W    (DATA_W),
  .NUM_BANKS (NUM_BANKS),
  .PIPE_MASK (PIPE_MASK),
  .WIDE      (WIDE)
) u_checks (
  .clk      (clk),
  .rstN     (rstN),
  .aRdEn    (aRdEn),
  .bRdEn    (bRdEn),
  .aRdValid (aRdValid),
  .bRdValid (bRdValid),
  .aRdData  (aRdData),
  .bRdData  (bRdData)
);

// File: tb/banked_dpram_bench.sv
`timescale 1ns/1ps
module banked_dpram_bench;

  localparam int DW    = 18;
  localparam int AW    = 7;
  localparam int WORDS = 128;
  localparam int NI    = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          aRdEn = 1'b0, bRdEn = 1'b0;
  logic [1:0]    bWrEn = 2'b00;
  logic [AW-1:0] aAddr = '0, bAddr = '0;
  logic [DW-1:0] bWrData = '0;

  logic [DW-1:0] aData [NI];
  logic [DW-1:0] bData [NI];
  logic          aVal  [NI];
  logic          bVal  [NI];

  // Latency per build from R3: base 1, deep (two registered levels) 3, wide (one level + wide reg) 3
  int lat [NI] = '{1, 3, 3};

  always #2.5 clk = ~clk;

  banked_dpram u_banked_dpram (
    .clk(clk), .rstN(rstN), .aRdEn(aRdEn), .aAddr(aAddr), .aRdData(aData[0]), .aRdValid(aVal[0]),
    .bRdEn(bRdEn), .bWrEn(bWrEn), .bAddr(bAddr), .bWrData(bWrData), .bRdData(bData[0]), .bRdValid(bVal[0]));

  banked_dpram #(.BANK_DEPTH(16), .NUM_BANKS(8), .PIPE_MASK(8'h03)) u_banked_dpram_deep (
    .clk(clk), .rstN(rstN), .aRdEn(aRdEn), .aAddr(aAddr), .aRdData(aData[1]), .aRdValid(aVal[1]),
    .bRdEn(bRdEn), .bWrEn(bWrEn), .bAddr(bAddr), .bWrData(bWrData), .bRdData(bData[1]), .bRdValid(bVal[1]));

  banked_dpram #(.PIPE_MASK(8'h01), .WIDE(1'b1)) u_banked_dpram_wide (
    .clk(clk), .rstN(rstN), .aRdEn(aRdEn), .aAddr(aAddr), .aRdData(aData[2]), .aRdValid(aVal[2]),
    .bRdEn(bRdEn), .bWrEn(bWrEn), .bAddr(bAddr), .bWrData(bWrData), .bRdData(bData[2]), .bRdValid(bVal[2]));

  logic [DW-1:0] refMem [WORDS];
  logic          pAV [NI][8];
  logic          pBV [NI][8];
  logic [DW-1:0] pAD [NI][8];
  logic [DW-1:0] pBD [NI][8];

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a * 2731) ^ 18'h15A3C;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  task automatic idleIn();
    aRdEn = 1'b0; bRdEn = 1'b0; bWrEn = 2'b00;
  endtask

  // One clock: model the request, advance, then compare every build.
  task automatic tick(input string tag);
    logic [DW-1:0] aOld, bOld;
    aOld = refMem[aAddr];
    bOld = refMem[bAddr];
    for (int d = 0; d < NI; d++) begin
      for (int i = 7; i > 0; i--) begin
        pAV[d][i] = pAV[d][i-1]; pAD[d][i] = pAD[d][i-1];
        pBV[d][i] = pBV[d][i-1]; pBD[d][i] = pBD[d][i-1];
      end
      pAV[d][0] = aRdEn; pAD[d][0] = aOld;
      pBV[d][0] = bRdEn; pBD[d][0] = bOld;
    end
    if (bWrEn[0]) refMem[bAddr][8:0]  = bWrData[8:0];
    if (bWrEn[1]) refMem[bAddr][17:9] = bWrData[17:9];
    @(posedge clk); #1;
    for (int d = 0; d < NI; d++) begin
      int k;
      k = lat[d] - 1;
      check(aVal[d] == pAV[d][k], tag, $sformatf("build%0d A valid", d), DW'(aVal[d]), DW'(pAV[d][k]));
      check(bVal[d] == pBV[d][k], tag, $sformatf("build%0d B valid", d), DW'(bVal[d]), DW'(pBV[d][k]));
      if (pAV[d][k]) check(aData[d] == pAD[d][k], tag, $sformatf("build%0d A data", d), aData[d], pAD[d][k]);
      if (pBV[d][k]) check(bData[d] == pBD[d][k], tag, $sformatf("build%0d B data", d), bData[d], pBD[d][k]);
    end
  endtask

  task automatic flush(input string tag);
    idleIn();
    repeat (4) tick(tag);
  endtask

  task automatic t_reset();
    for (int d = 0; d < NI; d++)
      for (int i = 0; i < 8; i++) begin
        pAV[d][i] = 1'b0; pBV[d][i] = 1'b0; pAD[d][i] = '0; pBD[d][i] = '0;
      end
    for (int a = 0; a < WORDS; a++) refMem[a] = '0;
    aRdEn = 1'b1; bRdEn = 1'b1;   // requests during reset must not raise valid
    repeat (3) @(posedge clk);
    #1;
    for (int d = 0; d < NI; d++) begin
      check(!aVal[d], "R1", $sformatf("build%0d A valid in reset", d), DW'(aVal[d]), '0);
      check(!bVal[d], "R1", $sformatf("build%0d B valid in reset", d), DW'(bVal[d]), '0);
    end
    idleIn();
    #1 rstN = 1'b1;
    tick("R1");
  endtask

  task automatic t_fill();
    for (int a = 0; a < WORDS; a++) begin
      bAddr = AW'(a); bWrEn = 2'b11; bWrData = pat(a);
      tick("R9");
    end
    idleIn();
    for (int i = 0; i < WORDS; i++) begin
      aRdEn = 1'b1; aAddr = AW'(i);
      bRdEn = 1'b1; bAddr = AW'(WORDS - 1 - i);
      tick("R9");
    end
    flush("R4");
  endtask

  task automatic t_halves();
    bAddr = 7'd20; bWrEn = 2'b10; bWrData = 18'h3FFFF; tick("R2");
    bAddr = 7'd33; bWrEn = 2'b01; bWrData = 18'h00000; tick("R2");
    idleIn();
    aRdEn = 1'b1; aAddr = 7'd20; bRdEn = 1'b1; bAddr = 7'd33; tick("R2");
    aAddr = 7'd33; bAddr = 7'd20; tick("R2");
    flush("R2");
  endtask

  task automatic t_readFirst();
    bAddr = 7'd50; bRdEn = 1'b1; bWrEn = 2'b11; bWrData = 18'h0BEEF; tick("R5");
    bWrEn = 2'b00; tick("R5");
    flush("R5");
  endtask

  task automatic t_collide();
    aRdEn = 1'b1; aAddr = 7'd60; bAddr = 7'd60; bWrEn = 2'b11; bWrData = 18'h12345; tick("R6");
    bWrEn = 2'b00; tick("R6");
    flush("R6");
  endtask

  task automatic t_latency();
    aRdEn = 1'b1; aAddr = 7'd7; bRdEn = 1'b1; bAddr = 7'd100; tick("R3");
    idleIn();
    bAddr = 7'd101; bWrEn = 2'b11; bWrData = 18'h2AAAA; tick("R3");  // write-only: no valid
    bWrEn = 2'b00;
    repeat (5) tick("R3");
  endtask

  task automatic t_hold();
    logic [DW-1:0] heldA [NI];
    logic [DW-1:0] heldB [NI];
    aRdEn = 1'b1; aAddr = 7'd77; bRdEn = 1'b1; bAddr = 7'd12; tick("R11");
    flush("R11");
    for (int d = 0; d < NI; d++) begin heldA[d] = aData[d]; heldB[d] = bData[d]; end
    bAddr = 7'd77; bWrEn = 2'b11; bWrData = 18'h01111; tick("R11");
    idleIn();
    repeat (3) tick("R11");
    for (int d = 0; d < NI; d++) begin
      check(aData[d] == heldA[d], "R11", $sformatf("build%0d A held", d), aData[d], heldA[d]);
      check(bData[d] == heldB[d], "R11", $sformatf("build%0d B held", d), bData[d], heldB[d]);
    end
  endtask

  task automatic t_lanes();
    int seqA [8] = '{3, 64, 1, 126, 2, 35, 0, 127};
    for (int i = 0; i < 8; i++) begin
      aRdEn = 1'b1; aAddr = AW'(seqA[i]);
      bRdEn = 1'b1; bAddr = AW'(seqA[7 - i] ^ 1);
      tick("R10");
    end
    flush("R10");
  endtask

  task automatic t_random();
    for (int i = 0; i < 400; i++) begin
      aRdEn   = 1'($urandom_range(0, 1));
      aAddr   = AW'($urandom_range(0, WORDS - 1));
      bRdEn   = 1'($urandom_range(0, 1));
      bWrEn   = 2'($urandom_range(0, 3));
      bAddr   = ($urandom_range(0, 3) == 0) ? aAddr : AW'($urandom_range(0, WORDS - 1));
      bWrData = DW'($urandom);
      tick("R7");
    end
    flush("R8");
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finishRun();
    end
  end

  initial begin
    t_reset();
    t_fill();
    t_halves();
    t_readFirst();
    t_collide();
    t_latency();
    t_hold();
    t_lanes();
    t_random();
    finishRun();
  end

endmodule